// File: doc/BRIEF.md
# One-shot sawtooth PWM timer with dead-time

The block holds a set of identical timer channels. Each one drives a complementary output pair and pulses an overflow flag once per period. A channel counts upward from a loadable starting value to its period value and then wraps to zero. Output A is set by two compare values: it toggles on the first compare match and again on the second, so a single pulse appears in every period. The second compare value waits in a temporary register until the first match has happened. New compare values are double-buffered, so software can update them while the channel runs without tearing a pulse. Output B is configured in one of two ways. It either uses its own buffered pair, with the same first-then-second scheme as A, or its edges are derived from A's pair with separate dead-time values, so the two outputs are never both high.

Software reaches each channel through a write-only register port. That port stays locked until a key is written. A start input holds one bit per channel, so that any set of enabled channels can begin on the same clock edge. Their phase offset is fixed by the starting counts written beforehand. A force strobe for each channel copies the buffers into the active compare registers at once. It is meant for programming before start or for an immediate change.

The register address is `{channel, select}`, with the select in bits 3:0. The select codes are: 0 key, 1 control, 2 period, 3 start count, 4 A first edge, 5 A second edge, 6 B first edge, 7 B second edge, 8 rise dead-time, 9 fall dead-time. The control bits are: bit 0 start enable, bit 1 dead-time enable, bit 2 A idle level, bit 3 B idle level.

Top module: `pwm_dt_timer`

## Requirements
- R1: A running counter goes up by one each clock and wraps from the period value to 0, so one period lasts period+1 clocks.
- R2: `ovf_o` is high for exactly one clock, the clock in which the counter holds 0 after a wrap.
- R3: A start count written through select 3 while the channel is stopped becomes the first counter value after start, which fixes the phase between channels started together. Such a write while running has no effect.
- R4: A channel starts on a clock in which its `start_i` bit is high, but only if control bit 0 is set. Channels started in the same clock stay aligned. Starting also transfers all buffers as a cycle end does.
- R5: Output A toggles on the clock after the counter equals active compare A and keeps its level at cycle end.
- R6: At cycle end, select 4 is copied to compare A and select 5 to temporary A. A match on A copies temporary A into compare A. A buffer written mid-period therefore takes effect from the next period, and A is high for counts in (first, second].
- R7: With dead-time off, output B uses selects 6 and 7 under the same scheme, and B is low for counts in (first, second] when its idle level is high.
- R8: With dead-time on, B's first edge is at A-first minus the fall value, clamped at 0, and B's second edge is at A-second plus the rise value, clamped at the period value.
- R9: The dead-time enable takes effect only at a transfer point (cycle end, start, force). Toggling it mid-period leaves the rest of that period unchanged.
- R10: A `force_i` pulse copies the buffers into the active and temporary compare registers on that clock.
- R11: Writes other than the key are ignored unless the last key write carried 0xA5 in bits 15:8.
- R12: While a channel is stopped, its outputs hold the idle levels from control bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | CH_W+4 | Channel index and register select |
| wr_data_i | input | DW | Write data |
| start_i | input | NUM_CH | Start bits, one per channel |
| force_i | input | NUM_CH | Immediate buffer transfer, one per channel |
| pin_a_o | output | NUM_CH | Output A of each channel |
| pin_b_o | output | NUM_CH | Output B of each channel |
| ovf_o | output | NUM_CH | Overflow pulse of each channel |

## Verification
The bench checks every cycle of whole periods against the pulse windows that the requirements imply. It covers a buffer written mid-period, which a design lacking the temporary register would apply to the current pulse as a stretched edge. It covers a force pulse, which is lost if the force loads only at cycle end. It covers a dead-time enable change mid-period, which a design reading the bit live would apply as an early B edge. It covers clamping with oversized dead-times, where an unclamped design wraps and loses the B pulse. The bench also checks start gating, the phase offset of two channels started together, start counts written while running, and locked writes, each of which shows up as a wrong overflow timing or a wrong idle level.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  typedef enum logic [3:0] {
    REG_KEY  = 4'd0,
    REG_CTRL = 4'd1,
    REG_PRD  = 4'd2,
    REG_CNT  = 4'd3,
    REG_A1   = 4'd4,
    REG_A2   = 4'd5,
    REG_B1   = 4'd6,
    REG_B2   = 4'd7,
    REG_DTR  = 4'd8,
    REG_DTF  = 4'd9
  } reg_sel_e;

  typedef struct packed {
    logic b_idle;
    logic a_idle;
    logic dt_en;
    logic start_en;
  } ctrl_t;

  localparam logic [7:0] UNLOCK_KEY = 8'hA5;
endpackage

// File: rtl/pwm_dt_regs.sv
module pwm_dt_regs
  import pwm_dt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] prd_o,
  output logic [DW-1:0] a1_o,
  output logic [DW-1:0] a2_o,
  output logic [DW-1:0] b1_o,
  output logic [DW-1:0] b2_o,
  output logic [DW-1:0] dtr_o,
  output logic [DW-1:0] dtf_o,
  output logic          cnt_wr_o,
  output logic [DW-1:0] cnt_val_o
);
  reg_sel_e sel_w;
  logic     wr_ok_w;
  logic     unlocked_q;

  assign sel_w   = reg_sel_e'(wr_sel_i);
  assign wr_ok_w = wr_en_i && (unlocked_q || sel_w == REG_KEY);

  assign cnt_wr_o  = wr_ok_w && sel_w == REG_CNT;
  assign cnt_val_o = wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      ctrl_o     <= '0;
      prd_o      <= '1;
      a1_o       <= '0;
      a2_o       <= '0;
      b1_o       <= '0;
      b2_o       <= '0;
      dtr_o      <= '0;
      dtf_o      <= '0;
    end else if (wr_ok_w) begin
      case (sel_w)
        REG_KEY:  unlocked_q <= (wr_data_i[15:8] == UNLOCK_KEY);
        REG_CTRL: ctrl_o     <= ctrl_t'(wr_data_i[3:0]);
        REG_PRD:  prd_o      <= wr_data_i;
        REG_A1:   a1_o       <= wr_data_i;
        REG_A2:   a2_o       <= wr_data_i;
        REG_B1:   b1_o       <= wr_data_i;
        REG_B2:   b2_o       <= wr_data_i;
        REG_DTR:  dtr_o      <= wr_data_i;
        REG_DTF:  dtf_o      <= wr_data_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_dt_deadtime.sv
module pwm_dt_deadtime #(
  parameter int DW = 32
) (
  input  logic          en_i,
  input  logic [DW-1:0] a1_i,
  input  logic [DW-1:0] a2_i,
  input  logic [DW-1:0] b1_i,
  input  logic [DW-1:0] b2_i,
  input  logic [DW-1:0] dtr_i,
  input  logic [DW-1:0] dtf_i,
  input  logic [DW-1:0] prd_i,
  output logic [DW-1:0] b1_o,
  output logic [DW-1:0] b2_o
);
  logic [DW:0]   late_w;
  logic [DW-1:0] early_w;
  logic [DW-1:0] late_clip_w;

  // B falls before A rises, B rises after A falls
  assign early_w     = (a1_i >= dtf_i) ? a1_i - dtf_i : '0;
  assign late_w      = {1'b0, a2_i} + {1'b0, dtr_i};
  assign late_clip_w = (late_w > {1'b0, prd_i}) ? prd_i : late_w[DW-1:0];

  assign b1_o = en_i ? early_w     : b1_i;
  assign b2_o = en_i ? late_clip_w : b2_i;
endmodule

// File: rtl/pwm_dt_edge.sv
module pwm_dt_edge #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          load_i,
  input  logic [DW-1:0] first_i,
  input  logic [DW-1:0] second_i,
  input  logic          idle_i,
  output logic          pin_o,
  output logic [DW-1:0] cmp_o
);
  logic [DW-1:0] tmp_q;
  logic          match_w;

  assign match_w = run_i && (cnt_i == cmp_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o <= '0;
      tmp_q <= '0;
    end else if (load_i) begin
      cmp_o <= first_i;
      tmp_q <= second_i;
    end else if (match_w) begin
      cmp_o <= tmp_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pin_o <= 1'b0;
    else if (!run_i)  pin_o <= idle_i;
    else if (match_w) pin_o <= ~pin_o;
  end
endmodule

// File: rtl/pwm_dt_channel.sv
module pwm_dt_channel
  import pwm_dt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          start_i,
  input  logic          force_i,
  output logic          pin_a_o,
  output logic          pin_b_o,
  output logic          ovf_o,
  output logic          run_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] prd_o,
  output logic [DW-1:0] cmp_a_o,
  output logic [DW-1:0] cmp_b_o
);
  ctrl_t         ctrl_w;
  logic [DW-1:0] a1_w, a2_w, b1_w, b2_w, dtr_w, dtf_w;
  logic [DW-1:0] b1_eff_w, b2_eff_w, cnt_val_w;
  logic          cnt_wr_w, start_go_w, end_w, load_w;

  pwm_dt_regs #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl_w),
    .prd_o     (prd_o),
    .a1_o      (a1_w),
    .a2_o      (a2_w),
    .b1_o      (b1_w),
    .b2_o      (b2_w),
    .dtr_o     (dtr_w),
    .dtf_o     (dtf_w),
    .cnt_wr_o  (cnt_wr_w),
    .cnt_val_o (cnt_val_w)
  );

  pwm_dt_deadtime #(.DW(DW)) u_dt (
    .en_i  (ctrl_w.dt_en),
    .a1_i  (a1_w),
    .a2_i  (a2_w),
    .b1_i  (b1_w),
    .b2_i  (b2_w),
    .dtr_i (dtr_w),
    .dtf_i (dtf_w),
    .prd_i (prd_o),
    .b1_o  (b1_eff_w),
    .b2_o  (b2_eff_w)
  );

  assign start_go_w = start_i && ctrl_w.start_en && !run_o;
  assign end_w      = run_o && (cnt_o == prd_o);
  assign load_w     = start_go_w || end_w || force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= end_w;
      if (start_go_w) run_o <= 1'b1;
      if (!run_o) begin
        if (cnt_wr_w) cnt_o <= cnt_val_w;
      end else begin
        cnt_o <= end_w ? '0 : cnt_o + 1'b1;
      end
    end
  end

  logic [1:0][DW-1:0] first_w, second_w, cmp_w;
  logic [1:0]         idle_w, pin_w;

  assign first_w[0]  = a1_w;
  assign second_w[0] = a2_w;
  assign idle_w[0]   = ctrl_w.a_idle;
  assign first_w[1]  = b1_eff_w;
  assign second_w[1] = b2_eff_w;
  assign idle_w[1]   = ctrl_w.b_idle;

  for (genvar e = 0; e < 2; e++) begin : g_edge
    pwm_dt_edge #(.DW(DW)) u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_o),
      .cnt_i    (cnt_o),
      .load_i   (load_w),
      .first_i  (first_w[e]),
      .second_i (second_w[e]),
      .idle_i   (idle_w[e]),
      .pin_o    (pin_w[e]),
      .cmp_o    (cmp_w[e])
    );
  end

  assign pin_a_o = pin_w[0];
  assign pin_b_o = pin_w[1];
  assign cmp_a_o = cmp_w[0];
  assign cmp_b_o = cmp_w[1];
endmodule

// File: rtl/pwm_dt_timer.sv
module pwm_dt_timer #(
  parameter  int NUM_CH = 2,
  parameter  int DW     = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW     = CH_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [NUM_CH-1:0] start_i,
  input  logic [NUM_CH-1:0] force_i,
  output logic [NUM_CH-1:0] pin_a_o,
  output logic [NUM_CH-1:0] pin_b_o,
  output logic [NUM_CH-1:0] ovf_o
);
  logic [NUM_CH-1:0] run_w;
  logic [DW-1:0]     cnt_w   [NUM_CH];
  logic [DW-1:0]     prd_w   [NUM_CH];
  logic [DW-1:0]     cmp_a_w [NUM_CH];
  logic [DW-1:0]     cmp_b_w [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel_w;
    assign sel_w = wr_en_i && (wr_addr_i[AW-1:4] == CH_W'(g));

    pwm_dt_channel #(.DW(DW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (sel_w),
      .wr_sel_i  (wr_addr_i[3:0]),
      .wr_data_i (wr_data_i),
      .start_i   (start_i[g]),
      .force_i   (force_i[g]),
      .pin_a_o   (pin_a_o[g]),
      .pin_b_o   (pin_b_o[g]),
      .ovf_o     (ovf_o[g]),
      .run_o     (run_w[g]),
      .cnt_o     (cnt_w[g]),
      .prd_o     (prd_w[g]),
      .cmp_a_o   (cmp_a_w[g]),
      .cmp_b_o   (cmp_b_w[g])
    );
  end
endmodule

// File: rtl/pwm_dt_timer_chk.sv
module pwm_dt_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int DW     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] run_i,
  input logic [DW-1:0]     cnt_i   [NUM_CH],
  input logic [DW-1:0]     prd_i   [NUM_CH],
  input logic [DW-1:0]     cmp_a_i [NUM_CH],
  input logic [DW-1:0]     cmp_b_i [NUM_CH],
  input logic [NUM_CH-1:0] pin_a_i,
  input logic [NUM_CH-1:0] pin_b_i,
  input logic [NUM_CH-1:0] ovf_i
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[g] && cnt_i[g] == prd_i[g] |=> cnt_i[g] == '0);

    a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[g] && cnt_i[g] != prd_i[g] |=> cnt_i[g] == DW'($past(cnt_i[g]) + 1'b1));

    a_r2_ovf_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[g] |-> run_i[g] && cnt_i[g] == '0);

    a_r5_a_edge_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[g] && $past(run_i[g]) && pin_a_i[g] != $past(pin_a_i[g])
      |-> $past(cnt_i[g]) == $past(cmp_a_i[g]));

    a_r7_b_edge_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[g] && $past(run_i[g]) && pin_b_i[g] != $past(pin_b_i[g])
      |-> $past(cnt_i[g]) == $past(cmp_b_i[g]));

    a_r4_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[g] |=> run_i[g]);
  end
endmodule

bind pwm_dt_timer pwm_dt_timer_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_w),
  .cnt_i   (cnt_w),
  .prd_i   (prd_w),
  .cmp_a_i (cmp_a_w),
  .cmp_b_i (cmp_b_w),
  .pin_a_i (pin_a_o),
  .pin_b_i (pin_b_o),
  .ovf_i   (ovf_o)
);

// File: tb/sim_pwm_dt_timer.sv
`timescale 1ns/1ps
module sim_pwm_dt_timer;
  localparam int NCH = 2;
  localparam int AW  = 5;
  localparam int PRD = 19;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] start = '0;
  logic [NCH-1:0] frc = '0;
  logic [NCH-1:0] pin_a, pin_b, ovf;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  pwm_dt_timer #(.NUM_CH(NCH), .DW(32)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .start_i   (start),
    .force_i   (frc),
    .pin_a_o   (pin_a),
    .pin_b_o   (pin_b),
    .ovf_o     (ovf)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    wr_en   = 1'b1;
    wr_addr = AW'((ch << 4) | sel);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_ovf(input int ch);
    while (!ovf[ch]) @(negedge clk);
  endtask

  // Checks a full period phase by phase; optional write at phase 1, force at phase 2
  task automatic meas(input int ch, input int ca, input int da, input int fb, input int rb,
                      input string tag, input bit do_wr = 0, input int wsel = 0,
                      input int wval = 0, input bit do_frc = 0);
    int bad_p = -1;
    int act = 0, exp = 0;
    wait_ovf(ch);
    for (int p = 0; p <= PRD; p++) begin
      bit ea = (p > ca) && (p <= da);
      bit eb = !((p > fb) && (p <= rb));
      if (bad_p < 0 && (pin_a[ch] != ea || pin_b[ch] != eb)) begin
        bad_p = p;
        act = {pin_a[ch], pin_b[ch]};
        exp = {ea, eb};
      end
      if (p == 1 && do_wr) begin
        wr_en = 1'b1; wr_addr = AW'((ch << 4) | wsel); wr_data = wval;
      end
      if (p == 2) begin
        wr_en = 1'b0;
        if (do_frc) frc[ch] = 1'b1;
      end
      if (p == 3) frc[ch] = 1'b0;
      @(negedge clk);
    end
    if (bad_p >= 0) $display("  phase %0d, {a,b}", bad_p);
    chk(bad_p < 0, tag, act, exp);
  endtask

  task automatic t_reset;
    chk(pin_a == 0 && pin_b == 0 && ovf == 0, "R12 reset idle outputs", {pin_a, pin_b, ovf}, 0);
  endtask

  task automatic t_protect;
    wr(0, 1, 32'h4);
    repeat (3) @(negedge clk);
    chk(pin_a[0] == 1'b0, "R11 locked write ignored", pin_a[0], 0);
    wr(0, 0, 32'h0000_A500);
    wr(0, 1, 32'h4);
    @(negedge clk);
    chk(pin_a[0] == 1'b1, "R12 idle level after unlocked write", pin_a[0], 1);
  endtask

  task automatic t_setup;
    wr(1, 0, 32'h0000_A500);
    wr(0, 1, 32'h8);  // start disabled, B idle high
    wr(0, 2, PRD); wr(0, 3, 0); wr(0, 4, 4); wr(0, 5, 12);
    wr(0, 6, 5);   wr(0, 7, 8); wr(0, 8, 2); wr(0, 9, 1);
    wr(1, 1, 32'h8);
    wr(1, 2, PRD); wr(1, 3, 5); wr(1, 4, 4); wr(1, 5, 7);
    wr(1, 6, 6);   wr(1, 7, 9);
  endtask

  task automatic t_start_gate;
    bit seen = 0;
    start = 2'b11;
    @(negedge clk);
    start = 2'b00;
    for (int k = 0; k < 30; k++) begin
      if (ovf != 0) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R4 start ignored without enable", seen, 0);
  endtask

  task automatic t_start_together;
    int f0 = -1, s0 = -1, f1 = -1, w0 = -1;
    wr(0, 1, 32'hB);  // start, dead-time, B idle high
    wr(1, 1, 32'h9);  // start, B idle high
    start = 2'b11;
    @(negedge clk);
    start = 2'b00;
    for (int k = 0; k < 45; k++) begin
      if (ovf[0] && f0 < 0) f0 = k;
      else if (ovf[0] && s0 < 0 && k > f0 + 1) s0 = k;
      if (ovf[1] && f1 < 0) f1 = k;
      if (f0 >= 0 && k == f0 + 1) w0 = ovf[0];
      @(negedge clk);
    end
    chk(f0 == PRD + 1, "R4 first overflow of ch0", f0, PRD + 1);
    chk(f1 == PRD + 1 - 5, "R3 start count gives phase offset", f1, PRD - 4);
    chk(w0 == 0, "R2 overflow lasts one clock", w0, 0);
    chk(s0 - f0 == PRD + 1, "R1 period length", s0 - f0, PRD + 1);
  endtask

  task automatic t_cnt_running;
    int gap = 0;
    wr(0, 3, 100);
    wait_ovf(0);
    @(negedge clk);
    gap = 1;
    while (!ovf[0]) begin gap++; @(negedge clk); end
    chk(gap == PRD + 1, "R3 start count ignored while running", gap, PRD + 1);
  endtask

  task automatic t_waveforms;
    meas(0, 4, 12, 3, 14, "R8 dead-time derived B edges");
    meas(1, 4, 7, 6, 9, "R7 B from own buffers, R5 A pulse");
  endtask

  task automatic t_double_buffer;
    meas(1, 4, 7, 6, 9, "R6 mid-period write waits", 1, 5, 15);
    meas(1, 4, 15, 6, 9, "R6 new second edge next period");
  endtask

  task automatic t_force;
    meas(1, 8, 15, 6, 9, "R10 force applies buffers now", 1, 4, 8, 1);
  endtask

  task automatic t_dt_switch;
    meas(0, 4, 12, 3, 14, "R9 enable change waits for cycle end", 1, 1, 32'h9);
    meas(0, 4, 12, 5, 8, "R9 disabled dead-time after cycle end");
  endtask

  task automatic t_clamp;
    wr(0, 9, 9);
    wr(0, 8, 10);
    wr(0, 1, 32'hB);
    wait_ovf(0);
    @(negedge clk);
    meas(0, 4, 12, 0, PRD, "R8 dead-time clamped to 0 and period");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_protect();
    t_setup();
    t_start_gate();
    t_start_together();
    t_cnt_running();
    t_waveforms();
    t_double_buffer();
    t_force();
    t_dt_switch();
    t_clamp();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule